// File: doc/BRIEF.md
# Merged Status Interrupt Controller

This block gathers three status events into one summary interrupt line. The first event is a change of the link-up level reported by the link monitor. The second is a rollover pulse from the statistics counter block. The third is a transmit error, which the block detects itself. A transmit error is any stop request from the transmitter that arrives while transmission is enabled and the transmit-success flag is low. The block owns the transmit-enable bit, and the transmitter sees it on an output. Each event latches its own pending flag. A pending flag drives the summary interrupt only while that source's enable bit is set.

Each source is acknowledged by a different side effect:
- A link event clears when software writes its enable bit to 0.
- A rollover clears when the counter register is read, which the block sees as a strobe.
- A transmit error clears when software writes transmit enable back to 1, or writes its enable bit to 0.

Software reaches the enable bits and the transmit-enable bit through a small write/read register port.

Top module: `evt_irq_merge`

## Requirements
- R1: After the first clock cycle that follows reset, any change of `link_ok` between two clock edges sets the link pending flag (`pend[0]`) at the next edge.
- R2: A write to the enable register (address 0; bit 0 link, bit 1 rollover, bit 2 transmit error) with bit 0 equal to 0 clears the link pending flag.
- R3: A `cnt_roll` pulse sets the rollover pending flag (`pend[1]`). A `cnt_rd` strobe clears it.
- R4: `tx_halt` clears transmit enable. When it arrives while transmit enable is 1 and `tx_succ` is 0, it also sets the transmit-error pending flag (`pend[2]`). With `tx_succ` at 1, no flag is set.
- R5: The transmit-error flag clears on a write of 1 to bit 0 of the transmit control register (address 1). It also clears on a write to the enable register with bit 2 equal to 0.
- R6: Synchronous active-high reset clears all enable bits, transmit enable, all pending flags and `irq`.
- R7: `irq` is a register. One cycle after any pending flag and its enable bit are both 1, `irq` is 1. One cycle after no enabled flag is pending, `irq` is 0.
- R8: When an event and its acknowledge land in the same cycle, the event wins and the flag stays set. When `tx_halt` and a write of 1 to transmit enable land together, transmit enable ends at 0.
- R9: A flag latched while its enable is 0 is still visible on `pend` but does not raise `irq`.
- R10: `reg_rdata` shows the enable bits at address 0 and transmit enable in bit 0 at address 1. All other bits and addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_ok | input | 1 | Link-up level from the link monitor |
| cnt_roll | input | 1 | Counter rollover pulse |
| tx_halt | input | 1 | Transmitter request to stop, which clears transmit enable |
| tx_succ | input | 1 | Transmit-success flag, sampled with `tx_halt` |
| cnt_rd | input | 1 | Strobe marking a read of the counter register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| tx_enable | output | 1 | Transmit enable bit |
| pend | output | 3 | Pending flags {txerr, rollover, link} |
| irq | output | 1 | Registered summary interrupt |

## Verification
The bench builds the block with its default parameters: a 2-bit address and 8-bit data, with the enable register at address 0 and transmit control at address 1. These values reach every register, the unused address and the unused data bits that must read 0. The directed cases cover a flag latched while its source is disabled, each acknowledge path, and collisions between an event and its acknowledge in the same cycle. They also cover a transmitter stop with success high that must not count as an error.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int NUM_SRC = 3;

    typedef enum int unsigned {
        SRC_LINK  = 0,
        SRC_ROLL  = 1,
        SRC_TXERR = 2
    } src_e;

    // Enable bits; packed order matches the enable register layout (bit 0 = link)
    typedef struct packed {
        logic txerr_en;
        logic roll_en;
        logic link_en;
    } en_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] set;
        logic [NUM_SRC-1:0] ack;
    } evt_bus_t;

    function automatic logic [NUM_SRC-1:0] en_vec(en_t e);
        return {e.txerr_en, e.roll_en, e.link_en};
    endfunction

    function automatic logic any_live(logic [NUM_SRC-1:0] p, en_t e);
        return |(p & en_vec(e));
    endfunction

endpackage

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 8,
    parameter int EN_ADDR = 0,
    parameter int TX_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              tx_halt,
    output en_t               en,
    output logic              tx_on,
    output logic              link_ack,
    output logic              txerr_ack,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_ADDR);
    localparam logic [ADDR_W-1:0] TX_A = ADDR_W'(TX_ADDR);

    logic wr_en_reg;
    logic wr_tx_reg;

    assign wr_en_reg = reg_wr && (reg_addr == EN_A);
    assign wr_tx_reg = reg_wr && (reg_addr == TX_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= '0;
            tx_on <= 1'b0;
        end else begin
            if (wr_en_reg)
                en <= en_t'(reg_wdata[NUM_SRC-1:0]);
            if (tx_halt)
                tx_on <= 1'b0;
            else if (wr_tx_reg)
                tx_on <= reg_wdata[0];
        end
    end

    assign link_ack  = wr_en_reg && !reg_wdata[SRC_LINK];
    assign txerr_ack = (wr_en_reg && !reg_wdata[SRC_TXERR]) ||
                       (wr_tx_reg && reg_wdata[0]);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == EN_A)
            reg_rdata[NUM_SRC-1:0] = en_vec(en);
        else if (reg_addr == TX_A)
            reg_rdata[0] = tx_on;
    end

    assert_halt_wins_R8: assert property (@(posedge clk) disable iff (rst)
        tx_halt |=> !tx_on);

    assert_tx_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_tx_reg && reg_wdata[0] && !tx_halt) |=> tx_on);

endmodule

// File: rtl/evt_irq_detect.sv
module evt_irq_detect
    import evt_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               link_ok,
    input  logic               cnt_roll,
    input  logic               tx_halt,
    input  logic               tx_succ,
    input  logic               tx_on,
    output logic [NUM_SRC-1:0] evt
);

    logic link_prev;
    logic primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            link_prev <= 1'b0;
            primed    <= 1'b0;
        end else begin
            link_prev <= link_ok;
            primed    <= 1'b1;
        end
    end

    always_comb begin
        evt            = '0;
        evt[SRC_LINK]  = primed && (link_ok != link_prev);
        evt[SRC_ROLL]  = cnt_roll;
        evt[SRC_TXERR] = tx_halt && tx_on && !tx_succ;
    end

endmodule

// File: rtl/evt_irq_cell.sv
module evt_irq_cell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
        else if (ack)
            pend <= 1'b0;
    end

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (ack && !set) |=> !pend);

endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 8,
    parameter int EN_ADDR = 0,
    parameter int TX_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_ok,
    input  logic              cnt_roll,
    input  logic              tx_halt,
    input  logic              tx_succ,
    input  logic              cnt_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_enable,
    output logic [2:0]        pend,
    output logic              irq
);

    en_t                en;
    logic               tx_on;
    logic               link_ack;
    logic               txerr_ack;
    logic [NUM_SRC-1:0] evt;
    evt_bus_t           bus;
    logic [NUM_SRC-1:0] pend_q;
    logic               irq_q;

    evt_irq_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EN_ADDR(EN_ADDR),
        .TX_ADDR(TX_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .tx_halt  (tx_halt),
        .en       (en),
        .tx_on    (tx_on),
        .link_ack (link_ack),
        .txerr_ack(txerr_ack),
        .reg_rdata(reg_rdata)
    );

    evt_irq_detect u_det (
        .clk     (clk),
        .rst     (rst),
        .link_ok (link_ok),
        .cnt_roll(cnt_roll),
        .tx_halt (tx_halt),
        .tx_succ (tx_succ),
        .tx_on   (tx_on),
        .evt     (evt)
    );

    always_comb begin
        bus.set             = evt;
        bus.ack             = '0;
        bus.ack[SRC_LINK]   = link_ack;
        bus.ack[SRC_ROLL]   = cnt_rd;
        bus.ack[SRC_TXERR]  = txerr_ack;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        evt_irq_cell u_cell (
            .clk (clk),
            .rst (rst),
            .set (bus.set[i]),
            .ack (bus.ack[i]),
            .pend(pend_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= any_live(pend_q, en);
    end

    assign pend      = pend_q;
    assign irq       = irq_q;
    assign tx_enable = tx_on;

    assert_txerr_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_halt && tx_enable && !tx_succ) |=> pend[SRC_TXERR]);

    assert_masked_R9: assert property (@(posedge clk) disable iff (rst)
        ((pend & en_vec(en)) == '0) |=> !irq);

    assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(pend != '0));

endmodule

// File: tb/evt_irq_merge_test.sv
module evt_irq_merge_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       link_ok, cnt_roll, tx_halt, tx_succ, cnt_rd, reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       tx_enable;
    logic [2:0] pend;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_irq_merge uut (
        .clk(clk), .rst(rst), .link_ok(link_ok), .cnt_roll(cnt_roll),
        .tx_halt(tx_halt), .tx_succ(tx_succ), .cnt_rd(cnt_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_enable(tx_enable), .pend(pend), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic t_reset();
        rst = 1; link_ok = 0; cnt_roll = 0; tx_halt = 0; tx_succ = 0;
        cnt_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(pend, 0, "R6 pend");
        chk(irq, 0, "R6 irq");
        chk(tx_enable, 0, "R6 tx_enable");
        reg_addr = 0; #1 chk(reg_rdata, 0, "R6 R10 enable read");
        reg_addr = 3; #1 chk(reg_rdata, 0, "R10 unused addr");
    endtask

    task automatic t_link();
        link_ok = 1;
        @(negedge clk);
        chk(pend, 3'b001, "R1 link rise");
        @(negedge clk);
        chk(irq, 0, "R9 masked link");
        wr(0, 8'h01);
        chk(pend, 3'b001, "R9 pend kept");
        @(negedge clk);
        chk(irq, 1, "R7 irq up");
        reg_addr = 0; #1 chk(reg_rdata, 8'h01, "R10 enable read");
        wr(0, 8'h00);
        chk(pend, 0, "R2 link ack");
        @(negedge clk);
        chk(irq, 0, "R7 irq down");
        link_ok = 0; reg_wr = 1; reg_addr = 0; reg_wdata = 0;
        @(negedge clk);
        reg_wr = 0;
        chk(pend, 3'b001, "R8 link vs ack");
        wr(0, 8'h00);
        chk(pend, 0, "R2 link ack again");
    endtask

    task automatic t_roll();
        wr(0, 8'h02);
        cnt_roll = 1; @(negedge clk); cnt_roll = 0;
        chk(pend, 3'b010, "R3 roll set");
        @(negedge clk);
        chk(irq, 1, "R7 roll irq");
        cnt_roll = 1; cnt_rd = 1; @(negedge clk); cnt_roll = 0; cnt_rd = 0;
        chk(pend, 3'b010, "R8 roll vs read");
        cnt_rd = 1; @(negedge clk); cnt_rd = 0;
        chk(pend, 0, "R3 roll ack");
        @(negedge clk);
        chk(irq, 0, "R7 roll irq down");
    endtask

    task automatic t_txerr();
        wr(0, 8'h04);
        wr(1, 8'h01);
        chk(tx_enable, 1, "R10 tx on");
        reg_addr = 1; #1 chk(reg_rdata, 8'h01, "R10 tx read");
        tx_halt = 1; tx_succ = 1; @(negedge clk); tx_halt = 0; tx_succ = 0;
        chk(tx_enable, 0, "R4 halt clears");
        chk(pend, 0, "R4 success no error");
        wr(1, 8'h01);
        tx_halt = 1; @(negedge clk); tx_halt = 0;
        chk(pend, 3'b100, "R4 error set");
        @(negedge clk);
        chk(irq, 1, "R7 txerr irq");
        wr(1, 8'h01);
        chk(pend, 0, "R5 ack by tx on");
        tx_halt = 1; @(negedge clk); tx_halt = 0;
        chk(pend, 3'b100, "R4 error again");
        wr(0, 8'h00);
        chk(pend, 0, "R5 ack by disable");
        wr(1, 8'h01);
        tx_halt = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 8'h01;
        @(negedge clk);
        tx_halt = 0; reg_wr = 0;
        chk(pend, 3'b100, "R8 error vs ack");
        chk(tx_enable, 0, "R8 halt over write");
        rst = 1; @(negedge clk); rst = 0;
        chk(pend, 0, "R6 pend after reset");
        chk(irq, 0, "R6 irq after reset");
    endtask

    initial begin
        t_reset();
        t_link();
        t_roll();
        t_txerr();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule